// File: doc/BRIEF.md
# Prescaled Global Timer with Per-Processor Comparators

This block is a memory-mapped timer shared by several processors. A single 64-bit up-counter advances once every (prescale+1) input clock cycles while the timer runs. Each processor owns a bank holding a 64-bit comparator, a 32-bit increment value, a sticky event flag and an interrupt line. When the counter passes a processor's comparator, that processor's flag is set. If periodic mode is on, the comparator is also moved forward by the increment, so the events repeat at a fixed interval.

Software reaches everything through one 32-byte window of 32-bit words. A processor-ID input picks the bank that the banked registers refer to. The control word mixes two kinds of bits. The run bit and the prescale field are shared by all processors. The compare, interrupt and periodic enables belong to the accessing processor.

Top module: `gtm_top`

## Requirements
- R1: With the run bit set, the counter increases by one every (prescale+1) clock cycles. The first step lands prescale+1 edges after the edge that sets the run bit. With the run bit clear, the counter holds its value.
- R2: The word offsets are 0x00 counter bits 31:0, 0x04 counter bits 63:32, 0x08 control, 0x0C event flag (bit 0), 0x10 comparator bits 31:0, 0x14 comparator bits 63:32 and 0x18 increment. A read of offset 0x1C returns zero. A read with a nonzero address in bits 1:0 returns zero, and a write to such an address changes nothing.
- R3: A write to either counter word is discarded while the run bit is set. While the run bit is clear, such a write replaces that 32-bit half of the counter.
- R4: A processor's event fires in a cycle only when three things hold: the shared run bit is set, that processor's compare enable is set, and its comparator is strictly below the counter. The event sets that processor's flag on the next edge.
- R5: An event in periodic mode with a nonzero increment adds the increment to the comparator on the same edge that sets the flag. With a zero increment, the comparator does not change. A bus write to a comparator word in that cycle takes priority for that word.
- R6: A processor's interrupt output is high exactly while its flag and its interrupt enable are both set. The flag stays set until software clears it, even after the timer stops.
- R7: Writing the flag register with bit 0 equal to 1 clears the flag, and writing it with bit 0 equal to 0 leaves the flag unchanged. If a clear and an event fall in the same cycle, the flag ends up set.
- R8: The control bits are: bit 0 run (shared), bit 1 compare enable (banked), bit 2 interrupt enable (banked), bit 3 periodic mode (banked), and bits 15:8 prescale (shared). A control write updates the shared bits and the accessing processor's banked bits. A control read returns the shared bits OR-ed with the accessing processor's banked bits. The comparator, increment and flag registers are banked by processor ID.
- R9: Reset clears the counter, the shared control bits, and every bank's control bits, flag, comparator and increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset inside the window |
| bus_cpu_i | input | CPU_W | ID of the accessing processor |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | NCPU | Interrupt line per processor |

## Verification
The hazard here is a compare event and a software clear of the same flag arriving on the same edge. The bench provokes it with a large increment, so the event fires in exactly one cycle. It then times a clear write so that its edge matches the edge where the flag is set. It judges the outcome by reading the flag as still set. A second clear, issued after that edge, must then leave the flag at zero, and the comparator must have moved forward by exactly one increment.

// File: rtl/gtm_pkg.sv
package gtm_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 2 * WORD_W;
    localparam int ADDR_W = 5;
    localparam int PRE_W  = 8;

    // control word bit positions
    localparam int CTL_RUN     = 0;
    localparam int CTL_CMP     = 1;
    localparam int CTL_IRQ     = 2;
    localparam int CTL_AUTO    = 3;
    localparam int CTL_PRE_LSB = 8;

    typedef enum logic [2:0] {
        REG_CNT_LO = 3'd0,
        REG_CNT_HI = 3'd1,
        REG_CTRL   = 3'd2,
        REG_FLAG   = 3'd3,
        REG_CMP_LO = 3'd4,
        REG_CMP_HI = 3'd5,
        REG_INC    = 3'd6,
        REG_NONE   = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic cmp_en;
        logic irq_en;
        logic auto_en;
    } bank_ctl_t;

endpackage

// File: rtl/gtm_prescaler.sv
module gtm_prescaler
    import gtm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PRE_W-1:0] prescale_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_q, st_d;
    logic    tick;

    always_comb begin
        st_d = st_q;
        tick = run_i && (st_q.cnt >= prescale_i);
        if (!run_i || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick;

    // a nonzero prescale never yields two ticks back to back
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && prescale_i != '0) |=> (!tick_o || prescale_i == '0)); // R1

endmodule

// File: rtl/gtm_counter.sv
module gtm_counter
    import gtm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            if (tick_i) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            if (wr_lo_i) begin
                st_d.cnt[WORD_W-1:0] = wdata_i;
            end
            if (wr_hi_i) begin
                st_d.cnt[CNT_W-1:WORD_W] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R1
    AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(cnt_o)); // R3

endmodule

// File: rtl/gtm_channel.sv
module gtm_channel
    import gtm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wr_ctl_i,
    input  bank_ctl_t         ctl_wdata_i,
    input  logic              wr_cmp_lo_i,
    input  logic              wr_cmp_hi_i,
    input  logic              wr_inc_i,
    input  logic              clr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output bank_ctl_t         ctl_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [WORD_W-1:0] inc_o,
    output logic              flag_o,
    output logic              irq_o
);

    typedef struct packed {
        bank_ctl_t         ctl;
        logic [CNT_W-1:0]  cmp;
        logic [WORD_W-1:0] inc;
        logic              flag;
    } ch_st_t;

    ch_st_t st_q, st_d;
    logic   evt;

    always_comb begin
        st_d = st_q;
        evt  = run_i && st_q.ctl.cmp_en && (st_q.cmp < cnt_i);

        if (wr_ctl_i) begin
            st_d.ctl = ctl_wdata_i;
        end
        if (wr_inc_i) begin
            st_d.inc = wdata_i;
        end

        // periodic step, then bus deposits override per half
        if (evt && st_q.ctl.auto_en && (st_q.inc != '0)) begin
            st_d.cmp = st_q.cmp + {{(CNT_W-WORD_W){1'b0}}, st_q.inc};
        end
        if (wr_cmp_lo_i) begin
            st_d.cmp[WORD_W-1:0] = wdata_i;
        end
        if (wr_cmp_hi_i) begin
            st_d.cmp[CNT_W-1:WORD_W] = wdata_i;
        end

        // set beats clear
        if (clr_i) begin
            st_d.flag = 1'b0;
        end
        if (evt) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o  = st_q.ctl;
    assign cmp_o  = st_q.cmp;
    assign inc_o  = st_q.inc;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & st_q.ctl.irq_en;

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_o); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o); // R7
    AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && ctl_o.auto_en && inc_o != '0 && !wr_cmp_lo_i && !wr_cmp_hi_i)
        |=> (cmp_o == $past(cmp_o) + {{(CNT_W-WORD_W){1'b0}}, $past(inc_o)})); // R5
    AST_NO_EVT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !flag_o && !wr_ctl_i) |=> !flag_o); // R4

endmodule

// File: rtl/gtm_top.sv
module gtm_top
    import gtm_pkg::*;
#(
    parameter int NCPU  = 2,
    parameter int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CPU_W-1:0]  bus_cpu_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic [NCPU-1:0]   irq_o
);

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] prescale;
    } shared_st_t;

    shared_st_t sh_q, sh_d;

    logic              aligned;
    reg_idx_e          idx;
    logic              acc_wr;
    logic              cpu_ok;
    logic              tick;
    logic [CNT_W-1:0]  cnt;
    bank_ctl_t         ctl_wr;

    bank_ctl_t         ctl_v  [NCPU];
    logic [CNT_W-1:0]  cmp_v  [NCPU];
    logic [WORD_W-1:0] inc_v  [NCPU];
    logic              flag_v [NCPU];

    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign idx     = reg_idx_e'(bus_addr_i[ADDR_W-1:2]);
    assign acc_wr  = bus_sel_i && bus_we_i && aligned;
    assign cpu_ok  = (int'(bus_cpu_i) < NCPU);

    assign ctl_wr.cmp_en  = bus_wdata_i[CTL_CMP];
    assign ctl_wr.irq_en  = bus_wdata_i[CTL_IRQ];
    assign ctl_wr.auto_en = bus_wdata_i[CTL_AUTO];

    // shared control state
    always_comb begin
        sh_d = sh_q;
        if (acc_wr && idx == REG_CTRL) begin
            sh_d.run      = bus_wdata_i[CTL_RUN];
            sh_d.prescale = bus_wdata_i[CTL_PRE_LSB +: PRE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    gtm_prescaler u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (sh_q.run),
        .prescale_i (sh_q.prescale),
        .tick_o     (tick)
    );

    gtm_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (sh_q.run),
        .tick_i  (tick),
        .wr_lo_i (acc_wr && idx == REG_CNT_LO),
        .wr_hi_i (acc_wr && idx == REG_CNT_HI),
        .wdata_i (bus_wdata_i),
        .cnt_o   (cnt)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_bank
        logic bank_wr;
        assign bank_wr = acc_wr && cpu_ok && (int'(bus_cpu_i) == i);

        gtm_channel u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .run_i       (sh_q.run),
            .cnt_i       (cnt),
            .wr_ctl_i    (bank_wr && idx == REG_CTRL),
            .ctl_wdata_i (ctl_wr),
            .wr_cmp_lo_i (bank_wr && idx == REG_CMP_LO),
            .wr_cmp_hi_i (bank_wr && idx == REG_CMP_HI),
            .wr_inc_i    (bank_wr && idx == REG_INC),
            .clr_i       (bank_wr && idx == REG_FLAG && bus_wdata_i[0]),
            .wdata_i     (bus_wdata_i),
            .ctl_o       (ctl_v[i]),
            .cmp_o       (cmp_v[i]),
            .inc_o       (inc_v[i]),
            .flag_o      (flag_v[i]),
            .irq_o       (irq_o[i])
        );
    end

    // read path
    bank_ctl_t         rd_ctl;
    logic [CNT_W-1:0]  rd_cmp;
    logic [WORD_W-1:0] rd_inc;
    logic              rd_flag;

    always_comb begin
        rd_ctl      = '0;
        rd_cmp      = '0;
        rd_inc      = '0;
        rd_flag     = 1'b0;
        bus_rdata_o = '0;
        if (cpu_ok) begin
            rd_ctl  = ctl_v[bus_cpu_i];
            rd_cmp  = cmp_v[bus_cpu_i];
            rd_inc  = inc_v[bus_cpu_i];
            rd_flag = flag_v[bus_cpu_i];
        end
        if (bus_sel_i && aligned) begin
            case (idx)
                REG_CNT_LO: bus_rdata_o = cnt[WORD_W-1:0];
                REG_CNT_HI: bus_rdata_o = cnt[CNT_W-1:WORD_W];
                REG_CTRL: begin
                    bus_rdata_o[CTL_RUN]                 = sh_q.run;
                    bus_rdata_o[CTL_CMP]                 = rd_ctl.cmp_en;
                    bus_rdata_o[CTL_IRQ]                 = rd_ctl.irq_en;
                    bus_rdata_o[CTL_AUTO]                = rd_ctl.auto_en;
                    bus_rdata_o[CTL_PRE_LSB +: PRE_W]    = sh_q.prescale;
                end
                REG_FLAG:   bus_rdata_o[0] = rd_flag;
                REG_CMP_LO: bus_rdata_o = rd_cmp[WORD_W-1:0];
                REG_CMP_HI: bus_rdata_o = rd_cmp[CNT_W-1:WORD_W];
                REG_INC:    bus_rdata_o = rd_inc;
                default:    bus_rdata_o = '0;
            endcase
        end
    end

    AST_RUN_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.run != $past(sh_q.run)) |-> $past(acc_wr && idx == REG_CTRL)); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o[0]) |-> flag_v[0]); // R6

endmodule

// File: tb/tb_gtm_top.sv
`timescale 1ns/1ps
module tb_gtm_top;

    localparam int NCPU  = 2;
    localparam int CPU_W = 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_sel, bus_we;
    logic [4:0]        bus_addr;
    logic [CPU_W-1:0]  bus_cpu;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [NCPU-1:0]   irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gtm_top #(.NCPU(NCPU), .CPU_W(CPU_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_cpu_i   (bus_cpu),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic        we;
        logic        cpu;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 5'h00, 32'h0,          32'h0,          4'd9}, // R9 counter
        '{1'b0, 1'b0, 5'h08, 32'h0,          32'h0,          4'd9}, // R9 control
        '{1'b1, 1'b0, 5'h00, 32'h1111_1111,  32'h0,          4'd3},
        '{1'b0, 1'b0, 5'h00, 32'h0,          32'h1111_1111,  4'd3}, // R3 stopped write
        '{1'b1, 1'b0, 5'h04, 32'h0000_0002,  32'h0,          4'd3},
        '{1'b0, 1'b1, 5'h04, 32'h0,          32'h0000_0002,  4'd3}, // R3 shared counter
        '{1'b1, 1'b0, 5'h08, 32'h0000_0306,  32'h0,          4'd8},
        '{1'b0, 1'b0, 5'h08, 32'h0,          32'h0000_0306,  4'd8}, // R8 OR of bits
        '{1'b0, 1'b1, 5'h08, 32'h0,          32'h0000_0300,  4'd8}, // R8 banked off
        '{1'b1, 1'b1, 5'h10, 32'h0000_ABCD,  32'h0,          4'd2},
        '{1'b1, 1'b1, 5'h14, 32'h0000_0001,  32'h0,          4'd2},
        '{1'b0, 1'b1, 5'h10, 32'h0,          32'h0000_ABCD,  4'd2}, // R2 cmp lo
        '{1'b0, 1'b1, 5'h14, 32'h0,          32'h0000_0001,  4'd2}, // R2 cmp hi
        '{1'b0, 1'b0, 5'h10, 32'h0,          32'h0,          4'd8}, // R8 cmp banked
        '{1'b1, 1'b1, 5'h18, 32'h0000_0005,  32'h0,          4'd2},
        '{1'b0, 1'b1, 5'h18, 32'h0,          32'h0000_0005,  4'd2}, // R2 inc
        '{1'b0, 1'b0, 5'h18, 32'h0,          32'h0,          4'd8}, // R8 inc banked
        '{1'b1, 1'b0, 5'h1C, 32'hFFFF_FFFF,  32'h0,          4'd2},
        '{1'b0, 1'b0, 5'h1C, 32'h0,          32'h0,          4'd2}, // R2 hole
        '{1'b0, 1'b0, 5'h01, 32'h0,          32'h0,          4'd2}, // R2 misaligned rd
        '{1'b1, 1'b0, 5'h01, 32'hFFFF_FFFF,  32'h0,          4'd2},
        '{1'b0, 1'b0, 5'h00, 32'h0,          32'h1111_1111,  4'd2}, // R2 misaligned wr
        '{1'b1, 1'b1, 5'h08, 32'h0000_0008,  32'h0,          4'd8},
        '{1'b0, 1'b0, 5'h08, 32'h0,          32'h0000_0006,  4'd8}, // R8 shared moved
        '{1'b0, 1'b1, 5'h08, 32'h0,          32'h0000_0008,  4'd8}, // R8 own bank
        '{1'b0, 1'b0, 5'h0C, 32'h0,          32'h0,          4'd6}  // R6 no flag
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all bus tasks start and end just after a falling edge
    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic cpu, input logic [4:0] addr, input logic [31:0] data);
        bus_sel = 1'b1; bus_we = 1'b1; bus_cpu = cpu; bus_addr = addr; bus_wdata = data;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic cpu, input logic [4:0] addr, output logic [31:0] data);
        bus_sel = 1'b1; bus_we = 1'b0; bus_cpu = cpu; bus_addr = addr;
        #1;
        data = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_cpu = '0; bus_wdata = '0;
        rst_n = 1'b0;
        @(negedge clk);
        do_reset();

        // register table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) begin
                wr(VECS[i].cpu, VECS[i].addr, VECS[i].data);
            end else begin
                rd(VECS[i].cpu, VECS[i].addr, v);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].exp);
            end
        end

        // R9: reset clears everything written above
        do_reset();
        rd(0, 5'h00, v); check("R9 counter lo", v, 32'h0);
        rd(1, 5'h14, v); check("R9 cmp hi", v, 32'h0);
        rd(1, 5'h18, v); check("R9 inc", v, 32'h0);
        rd(0, 5'h08, v); check("R9 ctrl", v, 32'h0);

        // R1 prescale 2: counter steps at E+3, E+6, ...
        wr(0, 5'h08, 32'h0000_0201);
        cyc(8);
        rd(0, 5'h00, v); check("R1 before step", v, 32'd2);
        cyc(1);
        rd(0, 5'h00, v); check("R1 at step", v, 32'd3);
        wr(0, 5'h00, 32'hFFFF_0000);
        rd(0, 5'h00, v); check("R3 lo locked", v, 32'd3);
        wr(0, 5'h04, 32'h0000_0005);
        rd(0, 5'h04, v); check("R3 hi locked", v, 32'd0);
        wr(0, 5'h08, 32'h0000_0200);
        cyc(4);
        rd(0, 5'h00, v); check("R1 held stopped", v, 32'd4);
        wr(0, 5'h00, 32'h0000_0010);
        rd(0, 5'h00, v); check("R3 write stopped", v, 32'h10);

        // R4 / R6: compare event and interrupt
        do_reset();
        wr(0, 5'h10, 32'd5);
        wr(0, 5'h08, 32'h0000_0007);
        cyc(6);
        check("R6 irq before event", {30'b0, irq}, 32'b00);
        cyc(1);
        check("R6 irq after event", {30'b0, irq}, 32'b01);
        rd(0, 5'h0C, v); check("R4 flag cpu0", v, 32'd1);
        rd(1, 5'h0C, v); check("R4 flag cpu1 disabled", v, 32'd0);
        wr(0, 5'h08, 32'h0000_0006);
        cyc(2);
        rd(0, 5'h0C, v); check("R6 flag sticky", v, 32'd1);
        wr(0, 5'h0C, 32'h0000_0000);
        rd(0, 5'h0C, v); check("R7 write zero", v, 32'd1);
        wr(0, 5'h0C, 32'h0000_0001);
        rd(0, 5'h0C, v); check("R7 write one", v, 32'd0);
        check("R6 irq cleared", {30'b0, irq}, 32'b00);

        // R5 periodic mode
        do_reset();
        wr(1, 5'h10, 32'd3);
        wr(1, 5'h08, 32'h0000_000A);
        wr(0, 5'h10, 32'd3);
        wr(0, 5'h18, 32'd4);
        wr(0, 5'h08, 32'h0000_000B);
        cyc(5);
        rd(0, 5'h10, v); check("R5 first step", v, 32'd7);
        cyc(4);
        rd(0, 5'h10, v); check("R5 second step", v, 32'd11);
        rd(1, 5'h10, v); check("R5 zero inc holds", v, 32'd3);
        rd(1, 5'h0C, v); check("R4 flag cpu1", v, 32'd1);
        check("R6 irq masked", {30'b0, irq}, 32'b00);

        // R7 clear and event on the same edge
        do_reset();
        wr(0, 5'h10, 32'd5);
        wr(0, 5'h18, 32'd100);
        wr(0, 5'h08, 32'h0000_000F);
        cyc(6);
        wr(0, 5'h0C, 32'h0000_0001);
        rd(0, 5'h0C, v); check("R7 set beats clear", v, 32'd1);
        wr(0, 5'h0C, 32'h0000_0001);
        rd(0, 5'h0C, v); check("R7 later clear", v, 32'd0);
        rd(0, 5'h10, v); check("R5 single step", v, 32'd105);

        finish_run();
    end

endmodule